// File: doc/BRIEF.md
# Rectangular Region Address Walker

This block generates the word addresses that one direction of a two-dimensional DMA transfer must visit. Software configures a base address, the number of words in each line, the number of lines and a gap (in words) inserted after every line. A start request latches that configuration and begins the walk. Each address leaves on a valid/ready stream towards a memory frontend and advances only when the frontend accepts it.

While a walk is pending or running the block holds busy high. When the last address has been accepted it raises a one-cycle done pulse that an interrupt unit can capture. The block can optionally hold each walk until an external synchronisation pulse arrives. In loop mode it re-arms itself after every done pulse, so a frame-oriented consumer can run forever until software clears the loop flag.

Top module: `rect_addr_walker`

## Requirements
- R1: After reset, busy, addrValid and donePulse are all 0.
- R2: Addresses are emitted in order. The first is the base address, and each next word of a line is the previous address plus 1. After the last word of a line the next address is that last address plus 1 plus the gap. So line L, word W is base + L*(lineLen+gap) + W.
- R3: While addrValid is 1 and addrReady is 0, addrValid stays 1 and addrData holds its value on the next cycle.
- R4: donePulse is high for exactly one cycle. It occurs only after every address of the walk has been accepted, and no further address of that walk follows.
- R5: busy goes high the cycle after an accepted start and stays high through the done cycle. Without loop mode it is 0 on the cycle after done. addrValid is never 1 while busy is 0.
- R6: A line length of 0 or a line count of 0 emits no address and still produces one done pulse.
- R7: With syncDisable at 0, no address is emitted until a syncPulse is seen. Busy is high while the walk waits. With syncDisable at 1 the walk proceeds without a pulse.
- R8: Base, line length, line count and gap are sampled only when a walk is armed. Changing them during a walk does not alter its addresses.
- R9: If loopMode is 1 in the done cycle, a new walk is armed with the configuration present then. busy stays 1, and the walk runs again.
- R10: startReq is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to arm a walk (taken when idle) |
| loopMode | input | 1 | Re-arm automatically after each done |
| syncDisable | input | 1 | 1: skip the wait for syncPulse |
| syncPulse | input | 1 | External synchronisation event |
| cfgBase | input | ADDR_W | First word address |
| cfgLineLen | input | CNT_W | Words per line |
| cfgLineCnt | input | CNT_W | Number of lines |
| cfgGap | input | ADDR_W | Words skipped after each line |
| addrValid | output | 1 | Address available |
| addrReady | input | 1 | Frontend accepts the address |
| addrData | output | ADDR_W | Word address |
| busy | output | 1 | Walk armed or running |
| donePulse | output | 1 | One-cycle completion event |

## Verification
The done pulse of one walk and the configuration reload of the next walk happen on the same clock edge in loop mode. The accept of the last address also lands right before them. This is provoked by running a looped walk with addrReady held high, so the last accept, the done cycle and the re-arm follow back to back. It is judged by busy staying high after done and by the second pass producing exactly the addresses the scoreboard expects. A second overlap is a start request arriving while a walk is running with different configuration inputs. The walk's addresses must still match the old configuration.

// File: rtl/rect_walk_pkg.sv
package rect_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_FINISH
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // sample configuration, reset counters
    logic step;  // advance to the next address
  } walkStrobe_t;
endpackage

// File: rtl/rect_walk_ctrl.sv
module rect_walk_ctrl
  import rect_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        loopMode,
  input  logic        syncDisable,
  input  logic        syncPulse,
  input  logic        addrReady,
  input  logic        cfgEmpty,
  input  logic        lastWord,
  input  logic        lastLine,
  output walkStrobe_t strobe,
  output logic        addrValid,
  output logic        busy,
  output logic        donePulse
);
  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cfgEmpty) stateNext = ST_FINISH;
        else if (syncDisable || syncPulse) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (addrReady) begin
          strobe.step = 1'b1;
          if (lastWord && lastLine) stateNext = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (loopMode) begin
          strobe.load = 1'b1;
          stateNext   = ST_WAIT;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign addrValid = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_FINISH);
endmodule

// File: rtl/rect_walk_dp.sv
module rect_walk_dp
  import rect_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgLineLen,
  input  logic [CNT_W-1:0]  cfgLineCnt,
  input  logic [ADDR_W-1:0] cfgGap,
  output logic [ADDR_W-1:0] addrData,
  output logic              cfgEmpty,
  output logic              lastWord,
  output logic              lastLine
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] curAddr, gapR;
  logic [CNT_W-1:0]  lenR, cntR, wordIdx, lineIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      gapR    <= '0;
      lenR    <= '0;
      cntR    <= '0;
      wordIdx <= '0;
      lineIdx <= '0;
    end else if (strobe.load) begin
      curAddr <= cfgBase;
      gapR    <= cfgGap;
      lenR    <= cfgLineLen;
      cntR    <= cfgLineCnt;
      wordIdx <= '0;
      lineIdx <= '0;
    end else if (strobe.step) begin
      if (lastWord) begin
        wordIdx <= '0;
        lineIdx <= lineIdx + CNT_ONE;
        curAddr <= curAddr + ADDR_ONE + gapR;
      end else begin
        wordIdx <= wordIdx + CNT_ONE;
        curAddr <= curAddr + ADDR_ONE;
      end
    end
  end

  assign addrData = curAddr;
  assign cfgEmpty = (lenR == '0) || (cntR == '0);
  assign lastWord = (wordIdx == lenR - CNT_ONE);
  assign lastLine = (lineIdx == cntR - CNT_ONE);
endmodule

// File: rtl/rect_addr_walker.sv
module rect_addr_walker
  import rect_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              loopMode,
  input  logic              syncDisable,
  input  logic              syncPulse,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgLineLen,
  input  logic [CNT_W-1:0]  cfgLineCnt,
  input  logic [ADDR_W-1:0] cfgGap,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addrData,
  output logic              busy,
  output logic              donePulse
);
  walkStrobe_t strobe;
  logic cfgEmpty, lastWord, lastLine;

  rect_walk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .loopMode(loopMode),
    .syncDisable(syncDisable), .syncPulse(syncPulse), .addrReady(addrReady),
    .cfgEmpty(cfgEmpty), .lastWord(lastWord), .lastLine(lastLine),
    .strobe(strobe), .addrValid(addrValid), .busy(busy), .donePulse(donePulse)
  );

  rect_walk_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase),
    .cfgLineLen(cfgLineLen), .cfgLineCnt(cfgLineCnt), .cfgGap(cfgGap),
    .addrData(addrData), .cfgEmpty(cfgEmpty), .lastWord(lastWord),
    .lastLine(lastLine)
  );
endmodule

// File: rtl/rect_addr_walker_chk.sv
module rect_addr_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              loopMode,
  input logic              addrValid,
  input logic              addrReady,
  input logic [ADDR_W-1:0] addrData,
  input logic              busy,
  input logic              donePulse
);
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady |=> addrValid && $stable(addrData));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r5_valid_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !addrValid);

  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse && !loopMode |=> !busy);

  a_r9_loop_rearms: assert property (@(posedge clk) disable iff (!rstN)
    donePulse && loopMode |=> busy);
endmodule

bind rect_addr_walker rect_addr_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .loopMode(loopMode), .addrValid(addrValid),
  .addrReady(addrReady), .addrData(addrData), .busy(busy),
  .donePulse(donePulse)
);

// File: tb/rect_addr_walker_tb_top.sv
module rect_addr_walker_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rstN, startReq, loopMode, syncDisable, syncPulse, addrReady;
  logic [AW-1:0] cfgBase, cfgGap, addrData;
  logic [CW-1:0] cfgLineLen, cfgLineCnt;
  logic addrValid, busy, donePulse;

  rect_addr_walker #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .loopMode(loopMode),
    .syncDisable(syncDisable), .syncPulse(syncPulse), .cfgBase(cfgBase),
    .cfgLineLen(cfgLineLen), .cfgLineCnt(cfgLineCnt), .cfgGap(cfgGap),
    .addrValid(addrValid), .addrReady(addrReady), .addrData(addrData),
    .busy(busy), .donePulse(donePulse)
  );

  int errors = 0;
  int checks = 0;
  int doneCount = 0;
  int acceptCount = 0;
  logic [AW-1:0] expQ[$];
  logic [AW-1:0] expV;
  logic [AW-1:0] stallAddr;
  logic stallSeen = 1'b0;
  bit readyRandom = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  string curReq = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushRect(input logic [AW-1:0] base, input int len,
                          input int cnt, input int gap);
    for (int l = 0; l < cnt; l++)
      for (int w = 0; w < len; w++)
        expQ.push_back(base + AW'(l * (len + gap) + w));
  endtask

  task automatic startWalk(input logic [AW-1:0] base, input int len,
                           input int cnt, input int gap);
    @(negedge clk);
    cfgBase = base; cfgLineLen = CW'(len); cfgLineCnt = CW'(cnt);
    cfgGap = AW'(gap); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone(input int target);
    wait (doneCount >= target);
  endtask

  // scoreboard monitor: drives ready, then judges what the next edge sees
  always @(negedge clk) begin
    if (rstN) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      addrReady = readyRandom ? lfsr[0] : 1'b1;
      if (stallSeen)
        check(addrValid && addrData == stallAddr, "R3", "stalled address moved",
              addrData, stallAddr);
      stallSeen = addrValid && !addrReady;
      stallAddr = addrData;
      if (addrValid && addrReady) begin
        acceptCount++;
        if (expQ.size() == 0) check(1'b0, "R4", "unexpected address", addrData, 0);
        else begin
          expV = expQ.pop_front();
          check(addrData == expV, curReq, "address", addrData, expV);
        end
      end
      if (donePulse) begin
        check(expQ.size() == 0, "R4", "addresses pending at done", expQ.size(), 0);
        doneCount++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int snap;
    rstN = 1'b0; startReq = 1'b0; loopMode = 1'b0; syncDisable = 1'b1;
    syncPulse = 1'b0; addrReady = 1'b0; cfgBase = '0; cfgGap = '0;
    cfgLineLen = '0; cfgLineCnt = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!addrValid, "R1", "addrValid after reset", addrValid, 0);
    check(!donePulse, "R1", "donePulse after reset", donePulse, 0);

    // R2 basic rectangle, always ready
    pushRect(32'd100, 4, 3, 5);
    startWalk(32'd100, 4, 3, 5);
    check(busy, "R5", "busy after start", busy, 1);
    waitDone(1);
    @(negedge clk);
    check(!busy, "R5", "busy after done", busy, 0);

    // R3 random backpressure
    readyRandom = 1'b1; curReq = "R3";
    pushRect(32'h1000, 5, 4, 0);
    startWalk(32'h1000, 5, 4, 0);
    waitDone(2);
    readyRandom = 1'b0; curReq = "R2";

    // single-word lines with gap
    pushRect(32'd7, 1, 6, 2);
    startWalk(32'd7, 1, 6, 2);
    waitDone(3);

    // R6 zero length and zero count
    snap = acceptCount;
    startWalk(32'd50, 0, 3, 1);
    waitDone(4);
    check(acceptCount == snap, "R6", "addresses for zero length", acceptCount, snap);
    startWalk(32'd50, 3, 0, 1);
    waitDone(5);
    check(acceptCount == snap, "R6", "addresses for zero count", acceptCount, snap);

    // R7 sync gate
    syncDisable = 1'b0; curReq = "R7";
    pushRect(32'd200, 3, 2, 1);
    startWalk(32'd200, 3, 2, 1);
    repeat (10) @(negedge clk);
    check(!addrValid, "R7", "address before sync", addrValid, 0);
    check(busy, "R7", "busy while waiting sync", busy, 1);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
    waitDone(6);
    syncDisable = 1'b1;

    // R8 / R10 config change and restart attempt during a walk
    curReq = "R8";
    pushRect(32'd300, 6, 3, 2);
    startWalk(32'd300, 6, 3, 2);
    cfgBase = 32'd9000; cfgLineLen = 16'd2; cfgLineCnt = 16'd2; cfgGap = 32'd40;
    startReq = 1'b1;
    repeat (3) @(negedge clk);
    startReq = 1'b0;
    waitDone(7);
    snap = acceptCount;
    repeat (5) @(negedge clk);
    check(!busy, "R10", "restart taken while busy", busy, 0);
    check(acceptCount == snap, "R10", "extra addresses", acceptCount, snap);

    // R9 loop mode
    curReq = "R9";
    loopMode = 1'b1;
    pushRect(32'd400, 2, 2, 3);
    startWalk(32'd400, 2, 2, 3);
    waitDone(8);
    pushRect(32'd400, 2, 2, 3);
    @(negedge clk);
    check(busy, "R9", "busy after looped done", busy, 1);
    loopMode = 1'b0;
    waitDone(9);
    @(negedge clk);
    check(!busy, "R9", "busy after final done", busy, 0);
    check(expQ.size() == 0, "R4", "leftover expected addresses", expQ.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule